// File: doc/BRIEF.md
# Multithreaded Core Issue and Shared Complex-Unit Arbiter

This block holds the issue logic for a cluster of small multithreaded cores that evaluate arithmetic expressions. Each core keeps a fixed number of hardware thread contexts. Each thread offers its next operation through a valid flag, a kind bit, a function code and a data word. In every cycle each core takes at most one operation from the lowest-numbered thread that is able to issue. A simple operation goes into that core's own fully pipelined simple unit. A complex operation (natural log, divide, exponent or float-to-int, selected by the function code) is placed in the core's single request slot.

All cores share one fully pipelined complex unit. A round-robin arbiter grants that unit to one requesting core per cycle. A thread that has issued a complex operation waits until a result carrying its own core and thread tag comes back. During that wait, the other threads of the same core keep issuing. The arithmetic is modelled as fixed-latency delay lines. Each delay line returns the tag and the operands of the operation unchanged, so that timing and ordering can be seen at the ports.

Top module: `mtc_cluster`

## Requirements
- R1: After reset no thread is waiting, no request slot is occupied, no result is valid on either result port, and the arbiter pointer is at core 0.
- R2: Each core takes at most one operation per cycle, shown as a combinational take bit at flat index core*NT+thread. A thread is eligible when its valid bit is high, it is not waiting, and either its kind bit is 0 (simple) or its core's request slot is empty. The eligible thread with the lowest index is taken.
- R3: A simple operation taken in cycle c appears on its core's simple result port in cycle c+LAT_S, with its thread number and data.
- R4: A thread whose complex operation (kind bit 1) is taken becomes waiting. It is not taken again until the complex result port shows its core and thread, and it is eligible from the cycle after that. Other threads of the core continue to issue while it waits.
- R5: In each cycle the arbiter grants at most one core, and only a core whose request slot is occupied. It picks the first occupied core when searching upward from the pointer, wrapping from NC-1 to 0.
- R6: After a grant to core g the pointer becomes (g+1) mod NC. When there is no grant, the pointer keeps its value.
- R7: A request slot that is not granted keeps its thread, function and data unchanged. While the slot is occupied, the core takes no further complex operation, but it may still take simple operations.
- R8: A request slot filled in cycle c is granted no earlier than cycle c+1. A request granted in cycle g appears on the complex result port in cycle g+LAT_C, with its core, thread, 2-bit function code and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | NC*NT | Thread has an operation ready, index core*NT+thread |
| op_cplx | input | NC*NT | 1 = complex operation, 0 = simple |
| op_fn | input | NC*NT*2 | Complex function code per thread |
| op_data | input | NC*NT*DW | Operand word per thread |
| op_take | output | NC*NT | Operation taken this cycle |
| s_valid | output | NC | Simple result valid per core |
| s_thread | output | NC*TW | Thread tag of simple result |
| s_data | output | NC*DW | Simple result data |
| c_valid | output | 1 | Complex result valid |
| c_core | output | CW | Core tag of complex result |
| c_thread | output | TW | Thread tag of complex result |
| c_fn | output | 2 | Function code of complex result |
| c_data | output | DW | Complex result data |

## Verification
The assertions assume three things about the block's inputs:
- A thread's kind, function and data stay stable for as long as it holds its valid bit.
- Only the block's own complex pipeline produces returns.
- Inputs change away from the clock edge.

The stimulus drives every input right after a rising edge and reads the combinational take bits before the next edge. It drops a thread's valid bit only after the edge that took its operation, so no operation is withdrawn mid-cycle. Results are only ever generated by operations the block itself accepted, so a return never arrives for a thread that is not waiting.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   typedef enum logic {
      KIND_SIMPLE  = 1'b0,
      KIND_COMPLEX = 1'b1
   } op_kind_e;

   typedef enum logic [1:0] {
      FN_LOG   = 2'd0,
      FN_DIV   = 2'd1,
      FN_EXP   = 2'd2,
      FN_F2INT = 2'd3
   } cx_fn_e;

   localparam int FN_W = 2;
endpackage

// File: rtl/mtc_prio_pick.sv
module mtc_prio_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   if (N < 2) begin : g_bad_n
      $error("mtc_prio_pick: N must be at least 2");
   end

   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!any && req[i]) begin
            any    = 1'b1;
            gnt[i] = 1'b1;
            idx    = IW'(i);
         end
      end
   end

   // R2: lowest index wins, at most one pick
   always_comb begin
      if (!$isunknown(req)) begin
         p_pick_onehot_r2 : assert ($onehot0(gnt));
         p_pick_any_r2    : assert (any == (req != '0));
      end
   end
endmodule

// File: rtl/mtc_rr_arb.sv
module mtc_rr_arb #(
   parameter int N  = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx,
   output logic          any
);
   if (N < 2) begin : g_bad_n
      $error("mtc_rr_arb: N must be at least 2");
   end

   logic [IW-1:0] ptr_q;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      any     = 1'b0;
      for (int k = 0; k < N; k++) begin
         int c;
         c = int'(ptr_q) + k;
         if (c >= N) c = c - N;
         if (!any && req[c]) begin
            any     = 1'b1;
            gnt[c]  = 1'b1;
            gnt_idx = IW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (any) begin
         ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
      end
   end

   p_grant_onehot_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_grant_in_req_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   p_grant_when_req_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0));
   p_ptr_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/mtc_pipe.sv
module mtc_pipe #(
   parameter int W   = 8,
   parameter int LAT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   if (LAT < 1) begin : g_bad_lat
      $error("mtc_pipe: LAT must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("mtc_pipe: W must be at least 1");
   end

   if (LAT == 1) begin : g_single
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) v_q <= 1'b0;
         else        v_q <= in_valid;
      end
      always_ff @(posedge clk) begin
         d_q <= in_data;
      end
      assign out_valid = v_q;
      assign out_data  = d_q;
   end else begin : g_chain
      logic [LAT-1:0] v_q;
      logic [W-1:0]   d_q [LAT];
      always_ff @(posedge clk) begin
         if (!rst_n) v_q <= '0;
         else        v_q <= {v_q[LAT-2:0], in_valid};
      end
      always_ff @(posedge clk) begin
         d_q[0] <= in_data;
         for (int i = 1; i < LAT; i++) begin
            d_q[i] <= d_q[i-1];
         end
      end
      assign out_valid = v_q[LAT-1];
      assign out_data  = d_q[LAT-1];
   end
endmodule

// File: rtl/mtc_core.sv
module mtc_core
   import mtc_pkg::*;
#(
   parameter int NT    = 4,
   parameter int DW    = 16,
   parameter int LAT_S = 4,
   localparam int TW   = $clog2(NT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NT-1:0]     op_valid,
   input  logic [NT-1:0]     op_cplx,
   input  logic [NT*FN_W-1:0] op_fn,
   input  logic [NT*DW-1:0]  op_data,
   output logic [NT-1:0]     op_take,
   output logic              cx_req,
   output logic [TW-1:0]     cx_thread,
   output logic [FN_W-1:0]   cx_fn,
   output logic [DW-1:0]     cx_data,
   input  logic              cx_gnt,
   input  logic              ret_valid,
   input  logic [TW-1:0]     ret_thread,
   output logic              s_valid,
   output logic [TW-1:0]     s_thread,
   output logic [DW-1:0]     s_data
);
   if (NT < 2) begin : g_bad_nt
      $error("mtc_core: NT must be at least 2");
   end

   logic [NT-1:0]   busy_q;
   logic [NT-1:0]   elig;
   logic [NT-1:0]   pick;
   logic [TW-1:0]   pick_idx;
   logic            pick_any;
   logic            pick_kind;
   logic            iss_simple;
   logic            iss_cplx;
   logic [DW-1:0]   pick_data;
   logic [FN_W-1:0] pick_fn;
   logic            req_q;
   logic [TW-1:0]   req_thr_q;
   logic [FN_W-1:0] req_fn_q;
   logic [DW-1:0]   req_data_q;

   // eligibility: ready, not waiting, complex only when slot free
   assign elig = op_valid & ~busy_q & ~(op_cplx & {NT{req_q}});

   mtc_prio_pick #(.N(NT)) u_pick (
      .req (elig),
      .gnt (pick),
      .idx (pick_idx),
      .any (pick_any)
   );

   assign op_take    = pick;
   assign pick_kind  = op_cplx[pick_idx];
   assign pick_data  = op_data[int'(pick_idx)*DW +: DW];
   assign pick_fn    = op_fn[int'(pick_idx)*FN_W +: FN_W];
   assign iss_simple = pick_any && (pick_kind == KIND_SIMPLE);
   assign iss_cplx   = pick_any && (pick_kind == KIND_COMPLEX);

   // waiting flags per thread
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         for (int t = 0; t < NT; t++) begin
            if (iss_cplx && pick[t])
               busy_q[t] <= 1'b1;
            else if (ret_valid && (int'(ret_thread) == t))
               busy_q[t] <= 1'b0;
         end
      end
   end

   // single request slot toward the shared unit
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (iss_cplx) begin
         req_q <= 1'b1;
      end else if (cx_gnt) begin
         req_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (iss_cplx) begin
         req_thr_q  <= pick_idx;
         req_fn_q   <= pick_fn;
         req_data_q <= pick_data;
      end
   end

   assign cx_req    = req_q;
   assign cx_thread = req_thr_q;
   assign cx_fn     = req_fn_q;
   assign cx_data   = req_data_q;

   mtc_pipe #(.W(TW + DW), .LAT(LAT_S)) u_simple (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (iss_simple),
      .in_data   ({pick_idx, pick_data}),
      .out_valid (s_valid),
      .out_data  ({s_thread, s_data})
   );

   p_take_valid_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_take & ~op_valid) == '0);
   p_wait_blocks_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_take & op_cplx) != '0 |=> (op_take & $past(op_take & op_cplx)) == '0);
   p_ret_only_waiting_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> busy_q[ret_thread]);
   p_req_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (cx_req && !cx_gnt) |=> (cx_req && $stable(cx_thread) && $stable(cx_fn)
                               && $stable(cx_data)));
   p_no_cx_pending_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      cx_req |-> (op_take & op_cplx) == '0);
   p_gnt_needs_req_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      cx_gnt |-> cx_req);
endmodule

// File: rtl/mtc_cluster.sv
module mtc_cluster
   import mtc_pkg::*;
#(
   parameter int NC    = 6,
   parameter int NT    = 4,
   parameter int DW    = 16,
   parameter int LAT_S = 4,
   parameter int LAT_C = 20,
   localparam int TW   = $clog2(NT),
   localparam int CW   = $clog2(NC),
   localparam int CXW  = CW + TW + FN_W + DW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NC*NT-1:0]     op_valid,
   input  logic [NC*NT-1:0]     op_cplx,
   input  logic [NC*NT*2-1:0]   op_fn,
   input  logic [NC*NT*DW-1:0]  op_data,
   output logic [NC*NT-1:0]     op_take,
   output logic [NC-1:0]        s_valid,
   output logic [NC*TW-1:0]     s_thread,
   output logic [NC*DW-1:0]     s_data,
   output logic                 c_valid,
   output logic [CW-1:0]        c_core,
   output logic [TW-1:0]        c_thread,
   output logic [1:0]           c_fn,
   output logic [DW-1:0]        c_data
);
   if (NC < 2) begin : g_bad_nc
      $error("mtc_cluster: NC must be at least 2");
   end
   if (LAT_C < 1 || LAT_S < 1) begin : g_bad_lat
      $error("mtc_cluster: latencies must be at least 1");
   end

   logic [NC-1:0]   cx_req;
   logic [NC-1:0]   cx_gnt;
   logic [CW-1:0]   gnt_idx;
   logic            gnt_any;
   logic [TW-1:0]   cx_thr  [NC];
   logic [FN_W-1:0] cx_fn   [NC];
   logic [DW-1:0]   cx_dat  [NC];
   logic [NC-1:0]   ret_hit;
   logic [CXW-1:0]  cx_in;

   for (genvar k = 0; k < NC; k++) begin : g_core
      assign ret_hit[k] = c_valid && (int'(c_core) == k);

      mtc_core #(.NT(NT), .DW(DW), .LAT_S(LAT_S)) u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .op_valid   (op_valid[k*NT +: NT]),
         .op_cplx    (op_cplx[k*NT +: NT]),
         .op_fn      (op_fn[k*NT*FN_W +: NT*FN_W]),
         .op_data    (op_data[k*NT*DW +: NT*DW]),
         .op_take    (op_take[k*NT +: NT]),
         .cx_req     (cx_req[k]),
         .cx_thread  (cx_thr[k]),
         .cx_fn      (cx_fn[k]),
         .cx_data    (cx_dat[k]),
         .cx_gnt     (cx_gnt[k]),
         .ret_valid  (ret_hit[k]),
         .ret_thread (c_thread),
         .s_valid    (s_valid[k]),
         .s_thread   (s_thread[k*TW +: TW]),
         .s_data     (s_data[k*DW +: DW])
      );
   end

   mtc_rr_arb #(.N(NC)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (cx_req),
      .gnt     (cx_gnt),
      .gnt_idx (gnt_idx),
      .any     (gnt_any)
   );

   always_comb begin
      cx_in = '0;
      for (int k = 0; k < NC; k++) begin
         if (cx_gnt[k]) cx_in = {CW'(k), cx_thr[k], cx_fn[k], cx_dat[k]};
      end
   end

   mtc_pipe #(.W(CXW), .LAT(LAT_C)) u_complex (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (gnt_any),
      .in_data   (cx_in),
      .out_valid (c_valid),
      .out_data  ({c_core, c_thread, c_fn, c_data})
   );

   p_reset_quiet_r1 : assert property (@(posedge clk)
      !rst_n |=> (!c_valid && s_valid == '0));
   p_grant_core_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |-> cx_req[gnt_idx]);
   p_ret_core_range_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      c_valid |-> (int'(c_core) < NC));
endmodule

// File: tb/mtc_cluster_test.sv
module mtc_cluster_test;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 6, NT = 4, DW = 16, TW = 2, CW = 3;
   localparam int LAT_S = 4, LAT_C = 20;
   // upper nibble: valid mask of core 3 (all simple), lower nibble: expected take
   localparam logic [7:0] PRIO_VEC [8] = '{8'h11, 8'h62, 8'hC4, 8'h88,
                                           8'hF1, 8'hA2, 8'h00, 8'hE2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC*NT-1:0]    op_valid = '0;
   logic [NC*NT-1:0]    op_cplx  = '0;
   logic [NC*NT*2-1:0]  op_fn    = '0;
   logic [NC*NT*DW-1:0] op_data  = '0;
   logic [NC*NT-1:0]    op_take;
   logic [NC-1:0]       s_valid;
   logic [NC*TW-1:0]    s_thread;
   logic [NC*DW-1:0]    s_data;
   logic                c_valid;
   logic [CW-1:0]       c_core;
   logic [TW-1:0]       c_thread;
   logic [1:0]          c_fn;
   logic [DW-1:0]       c_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mtc_cluster #(.NC(NC), .NT(NT), .DW(DW), .LAT_S(LAT_S), .LAT_C(LAT_C)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cplx(op_cplx),
      .op_fn(op_fn), .op_data(op_data), .op_take(op_take), .s_valid(s_valid),
      .s_thread(s_thread), .s_data(s_data), .c_valid(c_valid), .c_core(c_core),
      .c_thread(c_thread), .c_fn(c_fn), .c_data(c_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_op(input int k, input int t, input bit v, input bit cx,
                         input int fn, input int data);
      op_valid[k*NT+t]             = v;
      op_cplx[k*NT+t]              = cx;
      op_fn[(k*NT+t)*2 +: 2]       = 2'(fn);
      op_data[(k*NT+t)*DW +: DW]   = DW'(data);
   endtask

   function automatic int take(input int k, input int t);
      return int'(op_take[k*NT+t]);
   endfunction

   task automatic chk_cx(input string req, input int core, input int thr,
                         input int fn, input int data);
      chk(req, int'(c_valid), 1);
      chk(req, int'(c_core), core);
      chk(req, int'(c_thread), thr);
      chk(req, int'(c_fn), fn);
      chk(req, int'(c_data), data);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1: reset state
      chk("R1 s_valid", int'(s_valid), 0);
      chk("R1 c_valid", int'(c_valid), 0);
      chk("R1 take", int'(op_take), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 idle after reset", int'(op_take), 0);

      // R2: priority table on core 3, simple ops only
      foreach (PRIO_VEC[i]) begin
         for (int t = 0; t < NT; t++)
            set_op(3, t, PRIO_VEC[i][4+t], 1'b0, 0, 16'h0300 + t);
         #1;
         chk("R2 priority", int'(op_take[3*NT +: NT]), int'(PRIO_VEC[i][3:0]));
         tick();
      end
      for (int t = 0; t < NT; t++) set_op(3, t, 1'b0, 1'b0, 0, 0);
      repeat (LAT_S + 1) tick();

      // cycle A: complex on core0 thr0, simple on thr1
      set_op(0, 0, 1'b1, 1'b1, 2, 16'h1111);
      set_op(0, 1, 1'b1, 1'b0, 0, 16'h2222);
      #1;
      chk("R2 thr0 first", take(0, 0), 1);
      chk("R2 thr1 waits", take(0, 1), 0);
      tick(); // A+1
      chk("R4 waiting thr0 not taken", take(0, 0), 0);
      chk("R4 thr1 keeps issuing", take(0, 1), 1);
      tick(); // A+2
      set_op(0, 1, 1'b0, 1'b0, 0, 0);
      tick(); tick(); // A+4
      chk("R3 no early simple result", int'(s_valid[0]), 0);
      tick(); // A+5
      chk("R3 simple valid", int'(s_valid[0]), 1);
      chk("R3 simple thread", int'(s_thread[0 +: TW]), 1);
      chk("R3 simple data", int'(s_data[0 +: DW]), 16'h2222);
      repeat (15) tick(); // A+20
      chk("R8 no early complex", int'(c_valid), 0);
      chk("R4 still waiting", take(0, 0), 0);
      tick(); // A+21
      chk_cx("R8 complex result", 0, 0, 2, 16'h1111);
      chk("R4 not taken on return cycle", take(0, 0), 0);
      tick(); // A+22
      chk("R4 eligible after return", take(0, 0), 1);
      tick(); // A+23, granted now; pointer becomes 1
      set_op(0, 0, 1'b0, 1'b0, 0, 0);
      tick(); // D = A+24
      // R5/R6: cores 0, 2, 5 request together with pointer at 1
      set_op(0, 1, 1'b1, 1'b1, 1, 16'hA000);
      set_op(2, 1, 1'b1, 1'b1, 3, 16'hA002);
      set_op(5, 1, 1'b1, 1'b1, 0, 16'hA005);
      #1;
      chk("R2 complex take c0", take(0, 1), 1);
      chk("R2 complex take c5", take(5, 1), 1);
      tick(); // D+1
      set_op(0, 1, 1'b0, 1'b0, 0, 0);
      set_op(2, 1, 1'b0, 1'b0, 0, 0);
      set_op(5, 1, 1'b0, 1'b0, 0, 0);
      set_op(0, 2, 1'b1, 1'b1, 1, 16'h3333);
      set_op(0, 3, 1'b1, 1'b0, 0, 16'h4444);
      #1;
      chk("R7 no complex while pending", take(0, 2), 0);
      chk("R7 simple still issues", take(0, 3), 1);
      tick(); // D+2
      set_op(0, 3, 1'b0, 1'b0, 0, 0);
      #1;
      chk("R7 slot still pending", take(0, 2), 0);
      tick(); // D+3 core0 granted
      chk("R7 pending until granted", take(0, 2), 0);
      tick(); // D+4
      chk("R7 slot free after grant", take(0, 2), 1);
      tick(); // D+5
      set_op(0, 2, 1'b0, 1'b0, 0, 0);
      repeat (16) tick(); // D+21
      chk_cx("R5 first grant core2", 2, 1, 3, 16'hA002);
      tick(); // D+22
      chk_cx("R6 wrap to core5", 5, 1, 0, 16'hA005);
      tick(); // D+23
      chk_cx("R6 then core0", 0, 1, 1, 16'hA000);
      tick(); // D+24
      chk("R8 gap", int'(c_valid), 0);
      tick(); // D+25
      chk_cx("R8 held request result", 0, 2, 1, 16'h3333);
      tick(); // E = D+26, pointer is 1
      set_op(0, 3, 1'b1, 1'b1, 2, 16'hB000);
      set_op(1, 3, 1'b1, 1'b1, 3, 16'hB001);
      tick(); // E+1
      set_op(0, 3, 1'b0, 1'b0, 0, 0);
      set_op(1, 3, 1'b0, 1'b0, 0, 0);
      repeat (20) tick(); // E+21
      chk_cx("R6 pointer after core0 is core1", 1, 3, 3, 16'hB001);
      tick(); // E+22
      chk_cx("R5 core0 next", 0, 3, 2, 16'hB000);
      repeat (4) tick();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule